// File: doc/BRIEF.md
# Segmented Memory Block Mapper

This block lets an 8-bit processor with a 64 kB address space reach a 256 kB RAM pool. The pool is treated as sixteen 16 kB blocks, numbered 0 to 15. The processor space is cut into four 16 kB segments by its two top address bits, and each segment is steered to a block number held in a small parallel-port style register file. The translated 18-bit address comes out combinationally, so no cycle is added to any memory access.

A video fetcher that sees only 64 kB at a time gets a second mapping. Two extra address bits choose which 64 kB quarter of the pool it reads, and its four 16 kB windows fill that quarter in reverse block order. A video-cycle input decides which mapping drives the physical address.

The register file has two 8-bit ports. Each port has a direction register and a data register that share one offset, plus a control register. Bit 2 of the control register decides whether that shared offset reaches the direction register or the data register. Every mapping field is taken from the port's pin levels, and an input pin floats high. Because reset turns every pin into an input, reset leaves a fixed default mapping that is not the identity.

Top module: `segmap_top`

## Requirements
- R1: After reset, all direction, data and control registers hold 0. Every pin then reads high, so CPU segments 0, 1, 2 and 3 map to blocks 12, 13, 14 and 15, and video windows 0, 1, 2 and 3 map to blocks 15, 14, 13 and 12.
- R2: A register is selected only when `io_page_n` is low and `cpu_addr[7]` is 1. `cpu_addr[1:0]` picks the register: 0 is the port A window, 1 is port A control, 2 is the port B window and 3 is port B control. A write is taken on the clock edge while `wr_en` is high. A write with no register selected has no effect. `rdata` is 0 whenever no register is selected.
- R3: For each port, control bit 2 routes the window offset: 0 reaches the direction register and 1 reaches the data register. The control register reads back all 8 bits exactly as written.
- R4: A read of a data register returns the stored value on bits whose direction bit is 1 (output) and returns 1 on bits whose direction bit is 0 (input).
- R5: Each pin level equals the data bit when its direction bit is 1, and equals 1 when its direction bit is 0. All mapping fields below use these pin levels (A for port A, B for port B).
- R6: With `video_cycle` low, `phys_addr` = {block, `cpu_addr[13:0]`}, where the block comes from the segment `cpu_addr[15:14]`. Segment 0 uses block A[3:0] XOR 3, and segment 1 uses block A[7:4] XOR 2.
- R7: Segment 2 uses block {B[5:4], B[1:0] XOR 1}, and segment 3 uses block {B[5:4], B[3:2]}.
- R8: With `video_cycle` high, `phys_addr` = {B[7:6], NOT `vid_addr[15:14]`, `vid_addr[13:0]`}. Writing 0x0E as the port B output selects quarter 0, and writing 0xFF selects quarter 3.
- R9: `phys_addr` follows `video_cycle`, the addresses and the pins combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_page_n | input | 1 | Active-low strobe for the 256-byte I/O page |
| wr_en | input | 1 | Write enable for the register file |
| cpu_addr | input | 16 | Processor address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, 0 when no register is selected |
| video_cycle | input | 1 | High while the video fetcher owns the cycle |
| vid_addr | input | 16 | Video fetcher address (64 kB view) |
| phys_addr | output | 18 | Translated pool address |

## Verification
The bench builds the block with its default widths: 8-bit ports, 16 kB segments and 4-bit block numbers. This small enough configuration lets it drive all 256 output values through each port. After each value it checks the mapped block of every CPU segment, or of every video window, against its own arithmetic. It also tries mixed direction masks, writes that miss the select window, and the two quarter-select values.

// File: rtl/segmap_pkg.sv
package segmap_pkg;
  localparam int DW     = 8;
  localparam int OFF_W  = 14;
  localparam int BLK_W  = 4;
  localparam int PHYS_W = BLK_W + OFF_W;
  localparam int NPORT  = 2;
  localparam int SEL_BIT = 2;

  // pin level: output bits drive data, input bits float high
  function automatic logic [DW-1:0] pin_level(input logic [DW-1:0] dir,
                                              input logic [DW-1:0] dat);
    return dat | ~dir;
  endfunction

  // block for a CPU segment, chosen so all-high pins give 12..15
  function automatic logic [BLK_W-1:0] seg_block(input logic [DW-1:0] pa,
                                                 input logic [DW-1:0] pb,
                                                 input logic [1:0]    seg);
    case (seg)
      2'd0:    return pa[3:0] ^ 4'h3;
      2'd1:    return pa[7:4] ^ 4'h2;
      2'd2:    return {pb[5:4], pb[1:0] ^ 2'b01};
      default: return {pb[5:4], pb[3:2]};
    endcase
  endfunction

  // video: quarter from port B, windows fill it in reverse order
  function automatic logic [BLK_W-1:0] vid_block(input logic [DW-1:0] pb,
                                                 input logic [1:0]    win);
    return {pb[7:6], ~win};
  endfunction
endpackage

// File: rtl/segmap_decode.sv
module segmap_decode
  import segmap_pkg::*;
(
  input  logic             io_page_n,
  input  logic             wr_en,
  input  logic             addr_hi,
  input  logic [1:0]       reg_idx,
  output logic             sel,
  output logic [NPORT-1:0] wr_win,
  output logic [NPORT-1:0] wr_ctl
);
  assign sel = ~io_page_n & addr_hi;

  always_comb begin
    wr_win = '0;
    wr_ctl = '0;
    if (sel && wr_en) begin
      if (reg_idx[0]) wr_ctl[reg_idx[1]] = 1'b1;
      else            wr_win[reg_idx[1]] = 1'b1;
    end
  end
endmodule

// File: rtl/segmap_port.sv
module segmap_port
  import segmap_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_win,
  input  logic          wr_ctl,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] pin,
  output logic [DW-1:0] rd_win,
  output logic [DW-1:0] rd_ctl
);
  logic [DW-1:0] dir_q, dat_q, ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
      ctl_q <= '0;
    end else begin
      if (wr_ctl) ctl_q <= wdata;
      if (wr_win && !ctl_q[SEL_BIT]) dir_q <= wdata;
      if (wr_win &&  ctl_q[SEL_BIT]) dat_q <= wdata;
    end
  end

  assign pin    = pin_level(dir_q, dat_q);
  assign rd_win = ctl_q[SEL_BIT] ? pin : dir_q;
  assign rd_ctl = ctl_q;
endmodule

// File: rtl/segmap_xlate.sv
module segmap_xlate
  import segmap_pkg::*;
(
  input  logic [15:0]       cpu_addr,
  input  logic [15:0]       vid_addr,
  input  logic              video_cycle,
  input  logic [DW-1:0]     pin_a,
  input  logic [DW-1:0]     pin_b,
  output logic [PHYS_W-1:0] phys_addr
);
  logic [BLK_W-1:0] cpu_blk, vid_blk;

  assign cpu_blk = seg_block(pin_a, pin_b, cpu_addr[15:14]);
  assign vid_blk = vid_block(pin_b, vid_addr[15:14]);

  assign phys_addr = video_cycle ? {vid_blk, vid_addr[OFF_W-1:0]}
                                 : {cpu_blk, cpu_addr[OFF_W-1:0]};
endmodule

// File: rtl/segmap_top.sv
module segmap_top
  import segmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_page_n,
  input  logic              wr_en,
  input  logic [15:0]       cpu_addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              video_cycle,
  input  logic [15:0]       vid_addr,
  output logic [PHYS_W-1:0] phys_addr
);
  logic             reg_sel;
  logic [NPORT-1:0] wr_win, wr_ctl;
  logic [DW-1:0]    pin_v [NPORT];
  logic [DW-1:0]    rwin_v [NPORT];
  logic [DW-1:0]    rctl_v [NPORT];
  logic             wr_hit;
  logic [DW-1:0]    pin_a, pin_b;

  segmap_decode u_dec (
    .io_page_n (io_page_n),
    .wr_en     (wr_en),
    .addr_hi   (cpu_addr[7]),
    .reg_idx   (cpu_addr[1:0]),
    .sel       (reg_sel),
    .wr_win    (wr_win),
    .wr_ctl    (wr_ctl)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    segmap_port u_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_win (wr_win[p]),
      .wr_ctl (wr_ctl[p]),
      .wdata  (wdata),
      .pin    (pin_v[p]),
      .rd_win (rwin_v[p]),
      .rd_ctl (rctl_v[p])
    );
  end

  assign wr_hit = |{wr_win, wr_ctl};
  assign pin_a  = pin_v[0];
  assign pin_b  = pin_v[1];

  always_comb begin
    rdata = '0;
    if (reg_sel)
      rdata = cpu_addr[0] ? rctl_v[cpu_addr[1]] : rwin_v[cpu_addr[1]];
  end

  segmap_xlate u_xl (
    .cpu_addr    (cpu_addr),
    .vid_addr    (vid_addr),
    .video_cycle (video_cycle),
    .pin_a       (pin_a),
    .pin_b       (pin_b),
    .phys_addr   (phys_addr)
  );
endmodule

// File: rtl/segmap_checks.sv
module segmap_checks
  import segmap_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              io_page_n,
  input logic [15:0]       cpu_addr,
  input logic              video_cycle,
  input logic [15:0]       vid_addr,
  input logic [PHYS_W-1:0] phys_addr,
  input logic [DW-1:0]     rdata,
  input logic              wr_hit,
  input logic [DW-1:0]     pin_a,
  input logic [DW-1:0]     pin_b
);
  // R1: the first cycle out of reset has every pin high
  a_r1_pins_high: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (pin_a == '1 && pin_b == '1));

  // R2: no register selected gives a zero read
  a_r2_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    (io_page_n || !cpu_addr[7]) |-> rdata == '0);

  // R2: pins move only after a write that hits the register file
  a_r2_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> ($stable(pin_a) && $stable(pin_b)));

  // R9: the offset follows the owner of the cycle
  a_r9_offset_mux: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[OFF_W-1:0] == (video_cycle ? vid_addr[OFF_W-1:0] : cpu_addr[OFF_W-1:0]));

  // R8: video windows fill the quarter in reverse order
  a_r8_vid_window: assert property (@(posedge clk) disable iff (!rst_n)
    video_cycle |-> phys_addr[OFF_W+1:OFF_W] == ~vid_addr[15:14]);

  // R8: the video quarter comes from the top two port B pins
  a_r8_vid_quarter: assert property (@(posedge clk) disable iff (!rst_n)
    video_cycle |-> phys_addr[PHYS_W-1:PHYS_W-2] == pin_b[7:6]);
endmodule

bind segmap_top segmap_checks u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .io_page_n   (io_page_n),
  .cpu_addr    (cpu_addr),
  .video_cycle (video_cycle),
  .vid_addr    (vid_addr),
  .phys_addr   (phys_addr),
  .rdata       (rdata),
  .wr_hit      (wr_hit),
  .pin_a       (pin_a),
  .pin_b       (pin_b)
);

// File: tb/segmap_top_bench.sv
`timescale 1ns/1ps
module segmap_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_page_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        video_cycle = 1'b0;
  logic [15:0] vid_addr = '0;
  logic [17:0] phys_addr;

  int n_checks = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  segmap_top u_segmap_top (
    .clk(clk), .rst_n(rst_n), .io_page_n(io_page_n), .wr_en(wr_en),
    .cpu_addr(cpu_addr), .wdata(wdata), .rdata(rdata),
    .video_cycle(video_cycle), .vid_addr(vid_addr), .phys_addr(phys_addr)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input int val, input int strobe_n = 0,
                    input int hi = 1);
    @(negedge clk);
    io_page_n = strobe_n[0];
    cpu_addr  = 16'((hi << 7) | idx);
    wdata     = 8'(val);
    wr_en     = 1'b1;
    @(negedge clk);
    wr_en     = 1'b0;
    io_page_n = 1'b1;
  endtask

  task automatic rd_check(input string req, input int idx, input int exp);
    @(negedge clk);
    io_page_n = 1'b0;
    cpu_addr  = 16'(8'h80 | idx);
    #1 check(req, rdata, exp);
    io_page_n = 1'b1;
  endtask

  // expected block for a CPU segment from pin levels
  function automatic int exp_seg(input int pa, input int pb, input int s);
    case (s)
      0: return (pa % 16) ^ 3;
      1: return (pa / 16) ^ 2;
      2: return ((pb / 16) % 4) * 4 + ((pb % 4) ^ 1);
      default: return ((pb / 16) % 4) * 4 + ((pb / 4) % 4);
    endcase
  endfunction

  task automatic cpu_check(input string req, input int pa, input int pb);
    for (int s = 0; s < 4; s++) begin
      video_cycle = 1'b0;
      io_page_n   = 1'b1;
      cpu_addr    = 16'(s * 16384 + ((pa * 37 + s * 911) % 16384));
      #1 check(req, phys_addr,
               exp_seg(pa, pb, s) * 16384 + (pa * 37 + s * 911) % 16384);
    end
  endtask

  task automatic vid_check(input string req, input int pb);
    for (int w = 0; w < 4; w++) begin
      video_cycle = 1'b1;
      vid_addr    = 16'(w * 16384 + ((pb * 53 + w) % 16384));
      #1 check(req, phys_addr,
               ((pb / 64) * 4 + (3 - w)) * 16384 + (pb * 53 + w) % 16384);
    end
    video_cycle = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    rd_check("R1", 0, 0);
    rd_check("R1", 1, 0);
    rd_check("R1", 2, 0);
    rd_check("R1", 3, 0);
    cpu_check("R1", 255, 255);
    vid_check("R1", 255);

    // R2: writes outside the window are ignored
    wr(0, 8'hFF, 0, 0);
    wr(0, 8'hFF, 1, 1);
    rd_check("R2", 0, 0);
    @(negedge clk);
    io_page_n = 1'b1; cpu_addr = 16'h0080;
    #1 check("R2", rdata, 0);
    io_page_n = 1'b0; cpu_addr = 16'h0003;
    #1 check("R2", rdata, 0);
    io_page_n = 1'b1;

    // R3 / R4 / R5: mixed direction mask on port A
    wr(0, 8'h0F);
    rd_check("R3", 0, 8'h0F);
    wr(1, 8'hA4);
    rd_check("R3", 1, 8'hA4);
    wr(0, 8'h50);
    rd_check("R4", 0, 8'hF0);
    cpu_check("R5", 8'hF0, 255);

    // R6: full sweep of port A outputs
    wr(1, 8'h00); wr(0, 8'hFF); wr(1, 8'h04);
    for (int v = 0; v < 256; v++) begin
      wr(0, v);
      rd_check("R6", 0, v);
      cpu_check("R6", v, 255);
    end

    // R7 / R8: full sweep of port B outputs
    wr(3, 8'h00); wr(2, 8'hFF); wr(3, 8'h04);
    rd_check("R3", 3, 8'h04);
    for (int v = 0; v < 256; v++) begin
      wr(2, v);
      rd_check("R7", 2, v);
      cpu_check("R7", 255, v);
      vid_check("R8", v);
    end

    // R8: quarter select values
    wr(2, 8'h0E);
    vid_check("R8", 8'h0E);
    wr(2, 8'hFF);
    vid_check("R8", 8'hFF);

    // R9: same-cycle switch between owners
    @(negedge clk);
    cpu_addr = 16'h4123; vid_addr = 16'h0123; video_cycle = 1'b0;
    #1 check("R9", phys_addr, 255 * 16384 % 16384 + 13 * 16384 + 16'h0123);
    video_cycle = 1'b1;
    #1 check("R9", phys_addr, 15 * 16384 + 16'h0123);
    video_cycle = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule